// File: doc/BRIEF.md
# Generalized OR-Combine Unit

This unit takes a 64-bit operand and ORs it with copies of itself. Each copy has neighbouring groups of bits exchanged. Six butterfly stages, with group sizes 1, 2, 4, 8, 16 and 32 bits, run in ascending order. Each stage is switched on by one bit of a 6-bit control value. A stage that is switched on spreads every set bit to its partner position at that distance. So the control value chooses how far set bits spread.

Control value 7 is the most common setting. It enables the distance-1, 2 and 4 stages, so every byte becomes 0xFF if any of its bits is set and 0x00 if it is clear. This is the primitive that string routines use to find a terminating zero byte. A word-mode flag limits the operation to the low 32 bits, drops the 32-bit stage and zero-extends the result.

A separate byte-fold path computes the control-7 case directly by reducing each byte with OR. An optional output register loads on an input strobe and clears on a synchronous reset.

Top module: `orc_unit`

## Requirements
- R1: Stage i (i = 0..5) is enabled by ctrl bit i and has distance 2^i. When enabled, every result bit j of that stage is the OR of input bits j and j XOR 2^i. Stages are applied from i = 0 upward.
- R2: With ctrl = 0 and word_mode = 0, the result equals the operand.
- R3: With ctrl = 7 (byte form), each result byte is 0xFF when any bit of the matching operand byte is 1, and 0x00 when that byte is zero. This holds for every single-bit operand.
- R4: Bytes that hold only 0x01 are treated as non-zero. 0x0001000100010001 gives 0x00FF00FF00FF00FF, 0x0100010001000100 gives 0xFF00FF00FF00FF00, and 0x010055AA00401100 gives 0xFF00FFFF00FFFF00.
- R5: With word_mode = 1, only operand bits 31:0 are combined, result bits 63:32 are zero, and ctrl bit 5 has no effect.
- R6: With ctrl = 63 and word_mode = 0, the result is all ones for any non-zero operand and zero for a zero operand.
- R7: With REG_OUT = 1, the result register loads the combined value on a rising clock edge where in_valid is high. The value appears on the result port after that edge. With in_valid low, the result holds even if the operand, ctrl or word_mode change.
- R8: With rst high at a rising edge (synchronous, active high), the result register clears to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the result |
| in_valid | input | 1 | Strobe that loads a new result |
| operand | input | 64 | Value to combine |
| ctrl | input | 6 | Stage enables, bit i enables distance 2^i |
| word_mode | input | 1 | Use the low 32 bits and zero-extend the result |
| result | output | 64 | Combined value |

## Verification
The bench goes after the lone-low-bit byte (0x01). A zero detector built on borrow propagation loses that byte and returns 0x00 where 0xFF is due. Every single-bit operand in byte form checks that no byte leaks into its neighbour or drops a bit position. Random control values against a bit-level reference catch a stage with the wrong mask or distance, or stages applied in the wrong order. Word-mode runs with bit 5 set and random upper halves show whether the high half leaks into the result. Idle cycles with changing inputs, and a reset in mid-stream, show whether the register loads without a strobe or fails to clear.

// File: rtl/orc_pkg.sv
package orc_pkg;

    // Default datapath width and the stage count it implies.
    localparam int unsigned ORC_WIDTH  = 64;
    localparam int unsigned ORC_STAGES = $clog2(ORC_WIDTH);

    // Control value that selects the byte-wise form (stages 1, 2 and 4).
    localparam int unsigned ORC_BYTE_CTRL = 7;

    // Operating modes of the network.
    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_WORD = 1'b1
    } orc_mode_e;

endpackage

// File: rtl/orc_stage.sv
// One butterfly stage: OR the input with a copy in which neighbouring
// groups of 2**LOG_DIST bits trade places.
module orc_stage #(
    parameter int unsigned W        = 64,
    parameter int unsigned LOG_DIST = 0
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned DIST = 1 << LOG_DIST;

    // Lower-half mask: bit j set when bit LOG_DIST of j is clear.
    function automatic logic [W-1:0] lower_mask();
        logic [W-1:0] m;
        for (int j = 0; j < W; j++) begin
            m[j] = ((j >> LOG_DIST) & 1) == 0;
        end
        return m;
    endfunction

    localparam logic [W-1:0] LO_MASK = lower_mask();

    logic [W-1:0] moved_up;
    logic [W-1:0] moved_down;

    always_comb begin
        moved_up   = (din & LO_MASK) << DIST;
        moved_down = (din >> DIST) & LO_MASK;
        dout       = en ? (din | moved_up | moved_down) : din;
    end

endmodule

// File: rtl/orc_combine_net.sv
// Chain of butterfly stages in ascending distance, with word-mode gating.
module orc_combine_net #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic [CW-1:0] ctrl,
    input  logic          word_mode,
    output logic [W-1:0]  result
);
    localparam int unsigned HALF = W / 2;

    logic [W-1:0] lvl [CW+1];

    assign lvl[0] = word_mode ? {{(W-HALF){1'b0}}, operand[HALF-1:0]} : operand;

    for (genvar i = 0; i < CW; i++) begin : g_stage
        // Stages whose distance reaches the half width are not used in word mode.
        localparam bit WIDE_ONLY = (1 << i) >= HALF;
        logic stage_en;
        if (WIDE_ONLY) begin : g_wide
            assign stage_en = ctrl[i] & ~word_mode;
        end else begin : g_any
            assign stage_en = ctrl[i];
        end
        orc_stage #(.W(W), .LOG_DIST(i)) u_stage (
            .en   (stage_en),
            .din  (lvl[i]),
            .dout (lvl[i+1])
        );
    end

    assign result = word_mode ? {{(W-HALF){1'b0}}, lvl[CW][HALF-1:0]} : lvl[CW];

endmodule

// File: rtl/orc_byte_fold.sv
// Direct byte form: OR-reduce each byte and replicate the outcome.
module orc_byte_fold #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] operand,
    input  logic         word_mode,
    output logic [W-1:0] result
);
    localparam int unsigned NBYTES = W / 8;
    localparam int unsigned HBYTES = NBYTES / 2;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic any_set;
        assign any_set = |operand[8*b +: 8];
        if (b < HBYTES) begin : g_low
            assign result[8*b +: 8] = {8{any_set}};
        end else begin : g_high
            assign result[8*b +: 8] = {8{any_set & ~word_mode}};
        end
    end

endmodule

// File: rtl/orc_unit.sv
// Top: generalized OR-combine with a byte-form fast path and optional register.
module orc_unit
    import orc_pkg::*;
#(
    parameter int unsigned W       = ORC_WIDTH,
    parameter int unsigned CW      = $clog2(W),
    parameter bit          REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  operand,
    input  logic [CW-1:0] ctrl,
    input  logic          word_mode,
    output logic [W-1:0]  result
);
    localparam int unsigned HALF = W / 2;

    orc_mode_e     mode;
    logic [CW-1:0] ctrl_eff;
    logic          byte_sel;
    logic [W-1:0]  net_res;
    logic [W-1:0]  fold_res;
    logic [W-1:0]  comb_res;

    always_comb begin
        mode     = word_mode ? MODE_WORD : MODE_FULL;
        ctrl_eff = ctrl;
        if (mode == MODE_WORD) begin
            ctrl_eff[CW-1] = 1'b0;
        end
        byte_sel = (ctrl_eff == CW'(ORC_BYTE_CTRL));
    end

    orc_combine_net #(.W(W), .CW(CW)) u_net (
        .operand   (operand),
        .ctrl      (ctrl),
        .word_mode (word_mode),
        .result    (net_res)
    );

    orc_byte_fold #(.W(W)) u_fold (
        .operand   (operand),
        .word_mode (word_mode),
        .result    (fold_res)
    );

    assign comb_res = byte_sel ? fold_res : net_res;

    // R3: the fast path and the stage network agree on the byte form.
    p_byte_agree_r3: assert property (@(posedge clk) disable iff (rst)
        byte_sel |-> (fold_res == net_res));

    // R5: word mode never produces upper-half bits.
    p_word_upper_r5: assert property (@(posedge clk) disable iff (rst)
        word_mode |-> (net_res[W-1:HALF] == '0));

    // R6: all stages on spread any set bit everywhere.
    p_full_ones_r6: assert property (@(posedge clk) disable iff (rst)
        (!word_mode && (ctrl == '1) && (operand != '0)) |-> (net_res == '1));

    if (REG_OUT) begin : g_reg
        logic [W-1:0] res_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
            end else if (in_valid) begin
                res_q <= comb_res;
            end
        end
        assign result = res_q;

        // R7: without a strobe the register keeps its value.
        p_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(result));

        // R8: the first cycle after reset shows a cleared result.
        p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (result == '0));
    end else begin : g_comb
        assign result = comb_res;
    end

endmodule

// File: tb/orc_unit_tb.sv
`timescale 1ns/1ps
module orc_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [5:0]  ctrl = '0;
    logic        word_mode = 1'b0;
    logic [63:0] result;

    int total = 0;
    int fails = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    orc_unit #(.W(64), .REG_OUT(1'b1)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .operand   (operand),
        .ctrl      (ctrl),
        .word_mode (word_mode),
        .result    (result)
    );

    // Bit-level reference: partner of bit j at stage i is j XOR 2**i.
    function automatic logic [63:0] ref_comb(logic [63:0] op, logic [5:0] c, logic wm);
        logic [63:0] x;
        logic [63:0] y;
        x = wm ? {32'b0, op[31:0]} : op;
        for (int i = 0; i < 6; i++) begin
            if (c[i] && !(wm && i == 5)) begin
                for (int j = 0; j < 64; j++) y[j] = x[j] | x[j ^ (1 << i)];
                x = y;
            end
        end
        return wm ? {32'b0, x[31:0]} : x;
    endfunction

    function automatic logic [63:0] ref_byte(logic [63:0] op, logic wm);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = (|op[8*b +: 8]) ? 8'hFF : 8'h00;
        return wm ? {32'b0, r[31:0]} : r;
    endfunction

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [63:0] op, input logic [5:0] c, input logic wm,
                        input logic [63:0] exp, input string tag);
        @(negedge clk);
        operand = op; ctrl = c; word_mode = wm; in_valid = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle_drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Monitor: a strobe seen at an edge is compared at the next falling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (in_valid && !rst) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(result, 64'hx, "R7 unexpected result");
                end else begin
                    check(result, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [63:0] op;
        logic [63:0] held;
        logic [5:0]  c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(result, 64'h0, "R8 reset value");

        // R2: no stage enabled
        send(64'h0123_4567_89AB_CDEF, 6'd0, 1'b0, 64'h0123_4567_89AB_CDEF, "R2 pass-through");
        send(64'h8000_0000_0000_0001, 6'd0, 1'b0, 64'h8000_0000_0000_0001, "R2 pass-through edges");

        // R3: every single-bit operand in byte form
        for (int k = 0; k < 64; k++) begin
            op = 64'h1 << k;
            send(op, 6'd7, 1'b0, ref_byte(op, 1'b0), "R3 single bit");
        end
        send(64'h0, 6'd7, 1'b0, 64'h0, "R3 zero operand");
        send(64'hFFFF_FFFF_FFFF_FFFF, 6'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R3 all ones");

        // R4: lone low bits
        send(64'h0001_0001_0001_0001, 6'd7, 1'b0, 64'h00FF_00FF_00FF_00FF, "R4 vector a");
        send(64'h0100_0100_0100_0100, 6'd7, 1'b0, 64'hFF00_FF00_FF00_FF00, "R4 vector b");
        send(64'h0100_55AA_0040_1100, 6'd7, 1'b0, 64'hFF00_FFFF_00FF_FF00, "R4 vector c");

        // R1: random control values against the bit-level reference
        for (int k = 0; k < 200; k++) begin
            op = {$urandom, $urandom};
            c  = 6'($urandom);
            send(op, c, 1'b0, ref_comb(op, c, 1'b0), "R1 random stages");
        end
        send(64'h0000_0000_0000_0001, 6'b000011, 1'b0, 64'h0000_0000_0000_000F, "R1 stages 0 and 1");
        send(64'h0000_0000_0000_0001, 6'b100000, 1'b0, 64'h0000_0001_0000_0001, "R1 stage 5 alone");

        // R5: word mode, upper half random, bit 5 sometimes set
        for (int k = 0; k < 100; k++) begin
            op = {$urandom, $urandom};
            c  = 6'($urandom);
            send(op, c, 1'b1, ref_comb(op, c, 1'b1), "R5 word random");
        end
        send(64'hFFFF_FFFF_0000_0001, 6'b100000, 1'b1, 64'h0000_0000_0000_0001, "R5 bit5 ignored");
        send(64'hFFFF_FFFF_0001_0000, 6'd39, 1'b1, 64'h0000_0000_00FF_0000, "R5 byte form bit5 set");

        // R6: all stages
        send(64'h0000_0400_0000_0000, 6'd63, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R6 all stages");
        send(64'h0, 6'd63, 1'b0, 64'h0, "R6 all stages zero");
        idle_drain();

        // R7: idle cycles with changing inputs keep the result
        held = result;
        operand = 64'hDEAD_BEEF_0000_0000; ctrl = 6'd63; word_mode = 1'b0;
        @(negedge clk);
        operand = 64'h1; ctrl = 6'd7;
        @(negedge clk);
        check(result, held, "R7 hold without strobe");

        // R8: mid-run reset clears
        send(64'hFFFF_0000_FFFF_0000, 6'd7, 1'b0, 64'hFFFF_0000_FFFF_0000, "R7 load before reset");
        idle_drain();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(result, 64'h0, "R8 mid-run reset");

        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule